// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM up after reset and then keeps its contents alive. It first holds the row and column strobes inactive for a programmable start-up pause. It then runs a fixed number of warm-up cycles that each pulse RAS, and only after these does it raise `ready`. From then on a free-running interval timer marks a refresh as due once per refresh period. Each refresh is a column-before-row cycle: both column strobes drop first, and the row strobe follows while they are still low. The device supplies the row address from its own internal counter, so the block drives no address at all.

The block shares the strobe pins with an access controller, which multiplexes them. When a refresh is due, the block raises `ref_req`. The controller answers with `ref_gnt` once its own cycle has finished. The block then waits a full precharge interval before it touches any strobe, so a refresh never cuts into an access.

Refreshes that are still waiting for a grant are counted, up to a parameterised limit. A backlog is issued back-to-back under a single grant. Write enable and output enable stay inactive at all times, and the block never drives the data bus.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n` is 1, `cas_n` is 2'b11, `ready` is 0 and `ref_req` is 0.
- R2: After reset is released, `ras_n` and both `cas_n` bits stay high for at least PAUSE_CYC clock cycles.
- R3: After the pause, exactly INIT_CYCLES strobe cycles with a RAS low pulse occur, then `ready` rises. Once high, `ready` stays high until the next reset.
- R4: Both `cas_n` bits fall together. They are low for at least T_CSR cycles before `ras_n` falls, and they stay low for as long as `ras_n` is low.
- R5: `ras_n` stays low for at least T_RAS cycles per refresh. When it rises, both `cas_n` bits are high in the same cycle.
- R6: `ras_n` stays high for at least T_RP cycles between two low pulses. After `ready`, at least T_RP cycles separate the first cycle in which `ref_gnt` is seen high from the fall of `cas_n`.
- R7: `we_n` and `oe_n` are always 1, and `dq_oe` is always 0.
- R8: Once `ready` is high, one refresh becomes due every REF_PERIOD cycles. Over a long run with prompt grants, the number of refreshes matches the elapsed time divided by REF_PERIOD, within two.
- R9: After `ready`, `ref_req` is raised while any refresh is due. While `ref_gnt` is low, no strobe leaves its high level.
- R10: Due refreshes are counted up to PEND_MAX, and further ones are dropped. Under one grant, the whole backlog is issued back-to-back without `ref_req` falling.
- R11: `ref_req` is never high while `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller is idle and hands the strobes over |
| ref_req | output | 1 | Refresh wanted; held until the backlog is empty |
| ready | output | 1 | Initialisation complete, memory may be accessed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes for the lower and upper byte, active low |
| we_n | output | 1 | Write enable, held inactive |
| oe_n | output | 1 | Output enable, held inactive |
| dq_oe | output | 1 | Data bus drive enable, held off |

## Verification
The assertions check the following on every cycle:
- the strobes stay idle throughout the pause;
- CAS is already low when RAS falls;
- no strobe moves without a grant once the block is ready;
- `ready` is sticky and `ref_req` waits for it;
- the backlog count never exceeds its limit.

Other behaviour shows only in the bench scenarios. These cover the minimum pulse widths and precharge gaps and the exact number of warm-up cycles. They also cover the long-run refresh rate under randomly delayed grants, and the size of a saturated backlog burst after a long withheld grant.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_WAITG,
    ST_PRE,
    ST_CAS,
    ST_RAS,
    ST_REC
  } seq_st_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int REF_PERIOD = 780,
  parameter int PEND_MAX   = 4,
  localparam int PW        = $clog2(PEND_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          done,
  output logic [PW-1:0] pend
);

  localparam int TW = $clog2(REF_PERIOD);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          tick;

  always_comb begin
    tick   = run && (tcnt_q == TW'(REF_PERIOD - 1));
    tcnt_d = tcnt_q;
    if (!run)      tcnt_d = '0;
    else if (tick) tcnt_d = '0;
    else           tcnt_d = tcnt_q + 1'b1;

    pend_d = pend_q;
    unique case ({tick, done})
      2'b10:   if (pend_q != PW'(PEND_MAX)) pend_d = pend_q + 1'b1;
      2'b01:   if (pend_q != '0)            pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/dram_strobe_fsm.sv
module dram_strobe_fsm
  import dram_seq_pkg::*;
#(
  parameter int PAUSE_CYC   = 10000,
  parameter int INIT_CYCLES = 8,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pend_any,
  input  logic       gnt,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       ref_req,
  output logic       ready,
  output logic       ref_done,
  output logic       in_pause
);

  localparam int CMAX = max4(PAUSE_CYC, T_CSR, T_RAS, T_RP);
  localparam int CW   = $clog2(CMAX + 1);
  localparam int IW   = $clog2(INIT_CYCLES + 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] init_q, init_d;
  logic          rdy_q, rdy_d;
  logic          phase_end;

  always_comb begin
    phase_end = (cnt_q == '0);
    st_d      = st_q;
    cnt_d     = phase_end ? cnt_q : cnt_q - 1'b1;
    init_d    = init_q;
    rdy_d     = rdy_q;
    ref_done  = 1'b0;
    unique case (st_q)
      ST_PAUSE: if (phase_end) begin
        st_d  = ST_CAS;
        cnt_d = CW'(T_CSR - 1);
      end
      ST_IDLE: if (pend_any) st_d = ST_WAITG;
      ST_WAITG: if (gnt) begin
        st_d  = ST_PRE;
        cnt_d = CW'(T_RP - 1);
      end
      ST_PRE: if (phase_end) begin
        st_d  = ST_CAS;
        cnt_d = CW'(T_CSR - 1);
      end
      ST_CAS: if (phase_end) begin
        st_d  = ST_RAS;
        cnt_d = CW'(T_RAS - 1);
      end
      ST_RAS: if (phase_end) begin
        st_d  = ST_REC;
        cnt_d = CW'(T_RP - 1);
        if (rdy_q) ref_done = 1'b1;
        else       init_d   = init_q - 1'b1;
      end
      ST_REC: if (phase_end) begin
        if (!rdy_q) begin
          if (init_q == '0) begin
            rdy_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            st_d  = ST_CAS;
            cnt_d = CW'(T_CSR - 1);
          end
        end else if (pend_any && gnt) begin
          st_d  = ST_CAS;
          cnt_d = CW'(T_CSR - 1);
        end else begin
          st_d  = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      cnt_q  <= CW'(PAUSE_CYC);
      init_q <= IW'(INIT_CYCLES);
      rdy_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      init_q <= init_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ras_n    = (st_q != ST_RAS);
  assign cas_n    = {2{!((st_q == ST_CAS) || (st_q == ST_RAS))}};
  assign ready    = rdy_q;
  assign ref_req  = rdy_q && (st_q != ST_IDLE) && (st_q != ST_PAUSE);
  assign in_pause = (st_q == ST_PAUSE);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int PAUSE_CYC   = 10000,
  parameter int INIT_CYCLES = 8,
  parameter int REF_PERIOD  = 780,
  parameter int PEND_MAX    = 4,
  parameter int T_CSR       = 2,
  parameter int T_RAS       = 4,
  parameter int T_RP        = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_gnt,
  output logic       ref_req,
  output logic       ready,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  localparam int PW = $clog2(PEND_MAX + 1);

  logic          rst_sync_n;
  logic [PW-1:0] pend;
  logic          ref_done;
  logic          in_pause;

  dram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dram_ref_timer #(
    .REF_PERIOD (REF_PERIOD),
    .PEND_MAX   (PEND_MAX)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (ready),
    .done  (ref_done),
    .pend  (pend)
  );

  dram_strobe_fsm #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .T_CSR       (T_CSR),
    .T_RAS       (T_RAS),
    .T_RP        (T_RP)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pend_any (pend != '0),
    .gnt      (ref_gnt),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .ref_req  (ref_req),
    .ready    (ready),
    .ref_done (ref_done),
    .in_pause (in_pause)
  );

  assign we_n  = 1'b1;
  assign oe_n  = 1'b1;
  assign dq_oe = 1'b0;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int PEND_MAX = 4,
  localparam int PW      = $clog2(PEND_MAX + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ras_n,
  input logic [1:0]    cas_n,
  input logic          ref_gnt,
  input logic          ref_req,
  input logic          ready,
  input logic          in_pause,
  input logic [PW-1:0] pend
);

  assert_ras_idle_in_pause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (ras_n && cas_n == 2'b11));

  assert_cbr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && $past(ras_n)) |-> ($past(cas_n) == 2'b00));

  assert_grant_owned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && (!ras_n || cas_n != 2'b11)) |-> ref_gnt);

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ready) |-> ready);

  assert_pend_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= PW'(PEND_MAX));

  assert_req_after_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> ready);

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(.PEND_MAX(PEND_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ras_n    (ras_n),
  .cas_n    (cas_n),
  .ref_gnt  (ref_gnt),
  .ref_req  (ref_req),
  .ready    (ready),
  .in_pause (in_pause),
  .pend     (pend)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PAUSE      = 50;
  localparam int NINIT      = 8;
  localparam int PERIOD     = 200;
  localparam int PMAX       = 4;
  localparam int TCSR       = 2;
  localparam int TRAS       = 4;
  localparam int TRP        = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_gnt;
  logic       ref_req, ready, ras_n, we_n, oe_n, dq_oe;
  logic [1:0] cas_n;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(NINIT), .REF_PERIOD(PERIOD),
    .PEND_MAX(PMAX), .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_oe(dq_oe)
  );

  function automatic int burst_limit(input int n);
    return 2 + TRP + n * (TCSR + TRAS + TRP);
  endfunction

  function automatic int exp_refs(input int elapsed);
    return elapsed / PERIOD;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor state
  int cyc = 0, since_rst = 0;
  int ras_hi_run = 0, ras_lo_run = 0, cas_lo_run = 0, gnt_run = 0;
  int rasfalls = 0, init_falls = 0;
  bit first_cas = 1'b1;
  logic p_ras = 1'b1, p_cas = 1'b1, p_rdy = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      since_rst = 0; ras_hi_run = 0; ras_lo_run = 0; cas_lo_run = 0;
      gnt_run = 0; p_ras = 1'b1; p_cas = 1'b1; p_rdy = 1'b0; first_cas = 1'b1;
    end else begin
      since_rst++;
      chk(we_n && oe_n && !dq_oe, "R7", {we_n, oe_n, dq_oe}, 3'b110);
      if (ref_req && !ready) chk(1'b0, "R11", ref_req, 0);
      if (p_rdy && !ready) chk(1'b0, "R3 ready sticky", ready, 1);
      if (!ras_n) chk(cas_n == 2'b00, "R4 cas low under ras", cas_n, 0);
      if (p_cas && cas_n != 2'b11) begin
        chk(cas_n == 2'b00, "R4 cas pair", cas_n, 0);
        if (first_cas) chk(since_rst > PAUSE, "R2", since_rst - 1, PAUSE);
        first_cas = 1'b0;
        if (ready) chk(gnt_run >= TRP, "R6 grant to cas", gnt_run, TRP);
      end
      if (p_ras && !ras_n) begin
        chk(cas_lo_run >= TCSR, "R4 cas lead", cas_lo_run, TCSR);
        chk(ras_hi_run >= TRP, "R6 ras precharge", ras_hi_run, TRP);
        if (ready) chk(ref_gnt, "R9 strobe without grant", ref_gnt, 1);
        rasfalls++;
        if (!ready) init_falls++;
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo_run >= TRAS, "R5 ras width", ras_lo_run, TRAS);
        chk(cas_n == 2'b11, "R5 cas release", cas_n, 3);
      end
      ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
      ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
      cas_lo_run = (cas_n == 2'b00) ? cas_lo_run + 1 : 0;
      gnt_run    = ref_gnt ? gnt_run + 1 : 0;
      p_ras = ras_n; p_cas = cas_n[0]; p_rdy = ready;
    end
  end

  task automatic wait_req(input logic val, input int lim, output int waited);
    waited = 0;
    while (ref_req !== val && waited < lim) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    vectors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int w, base, c0, got, expn, dly;
    void'($urandom(32'd20240611));
    rst_n   = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && !ready && !ref_req, "R1",
        {ras_n, cas_n, ready, ref_req}, 5'b11100);
    rst_n = 1'b1;

    // power-up: pause then warm-up cycles
    w = 0;
    while (!ready && w < 4000) begin @(negedge clk); w++; end
    chk(ready, "R3 ready reached", ready, 1);
    chk(init_falls == NINIT, "R3 init count", init_falls, NINIT);
    chk(!ref_req, "R11 idle after init", ref_req, 0);

    // withheld grant: backlog saturates, then drains back-to-back
    wait_req(1'b1, 2 * PERIOD, w);
    chk(ref_req, "R8 first refresh due", ref_req, 1);
    repeat ((PMAX + 2) * PERIOD + PERIOD / 2) @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && ref_req, "R9 hold off without grant",
        {ras_n, cas_n, ref_req}, 4'b1111);
    base = rasfalls;
    ref_gnt = 1'b1;
    wait_req(1'b0, 500, w);
    ref_gnt = 1'b0;
    chk(rasfalls - base == PMAX, "R10 saturated burst", rasfalls - base, PMAX);
    chk(w <= burst_limit(PMAX), "R10 back-to-back", w, burst_limit(PMAX));

    // grant already present when the request appears
    ref_gnt = 1'b1;
    base = rasfalls;
    wait_req(1'b1, 2 * PERIOD, w);
    wait_req(1'b0, 200, w);
    ref_gnt = 1'b0;
    chk(rasfalls - base == 1, "R9 early grant single refresh", rasfalls - base, 1);

    // random grant latency, long-run rate
    c0 = cyc;
    base = rasfalls;
    repeat (40) begin
      wait_req(1'b1, 2 * PERIOD, w);
      dly = $urandom_range(0, 40);
      repeat (dly) @(negedge clk);
      chk(ref_req && ras_n, "R9 waiting for grant", {ref_req, ras_n}, 3);
      ref_gnt = 1'b1;
      wait_req(1'b0, 200, w);
      ref_gnt = 1'b0;
    end
    got  = rasfalls - base;
    expn = exp_refs(cyc - c0);
    chk(got >= expn - 2 && got <= expn + 2, "R8 refresh rate", got, expn);

    // reset again mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && !ready && !ref_req, "R1 re-reset",
        {ras_n, cas_n, ready, ref_req}, 5'b11100);
    finish_run();
  end

endmodule